// File: doc/BRIEF.md
# Split-aware round-robin bus arbiter

This block decides which of three bus masters drives the address phase of a shared, pipelined bus. Each master raises a request line and receives a one-hot grant. The arbiter also reports the address-phase owner as a small number, and it tracks which master owns the data phase that is in flight. It watches the bus handshake from the slaves: the ready line, the two-bit response code, the two-bit transfer type, and a per-master release vector.

Grants rotate fairly. The search begins with the master just after the one granted most recently. When a slave answers with a SPLIT response, the master whose data phase received it is taken out of arbitration. It stays out until some slave sets that master's bit on the release vector. A RETRY response does not take the master out. It moves the master to the back of the queue for the re-arbitration that follows. A release that arrives while a RETRY is under way is always honoured. This prevents the case where the slave believes it has freed a master but the arbiter still waits for the release, which would deadlock the bus.

There is no data stream through the block. All pins are plain control signals, sampled on the rising clock edge, and nothing applies back-pressure.

Top module: `split_rr_arbiter`

## Requirements
- R1: After reset (active-low `rst_n`), no grant is asserted, `owner_o` holds the idle code 3, every master is eligible, and master 0 has top priority in the first arbitration.
- R2: On every cycle with ready high and a transfer type other than BUSY (2'b01), the grant is recomputed. The grant goes to the first master that is requesting and not blocked, searching upward with wraparound from the master after the one granted most recently. The new grant is visible after that clock edge.
- R3: At most one grant bit is ever set. The grant does not change on a cycle where ready is low or the transfer type is BUSY (2'b01).
- R4: `owner_o` takes the value of the previous cycle's grant (encoded 0..2, or 3 when none) only on a cycle with ready high and a transfer type other than BUSY. On all other cycles it holds. The data-phase owner takes the address-phase owner on every ready-high cycle.
- R5: A SPLIT response (code 2'b11) seen while ready is low blocks the current data-phase owner. A blocked master is never granted, even while it requests.
- R6: A master stays blocked until its bit on `release_i` is high. A release bit clears the block in that cycle. If a block and a release for the same master arrive together, the release wins.
- R7: A release bit that arrives during either cycle of a RETRY response (code 2'b10) still unblocks its master.
- R8: On the second cycle of a RETRY response (ready high, code 2'b10), the search starts after the retried data-phase owner. Other requesting masters are therefore served first, and the retried master is not blocked.
- R9: If no eligible master is requesting, master 0 receives the grant as the default master. If master 0 is itself blocked, no grant is given, and `owner_o` then shows 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 3 | Bus request, one bit per master |
| grant_o | output | 3 | One-hot bus grant, one bit per master |
| owner_o | output | 2 | Address-phase owner, 0..2, or 3 for none |
| bus_ready_i | input | 1 | Slave ready; low stretches the current phase |
| bus_resp_i | input | 2 | Response code: 00 OKAY, 01 ERROR, 10 RETRY, 11 SPLIT |
| bus_trans_i | input | 2 | Transfer type: 00 IDLE, 01 BUSY, 10 NONSEQ, 11 SEQ |
| release_i | input | 3 | Per-master release from slaves after a SPLIT |

## Verification
A block bit that is stuck set shows up at the ports one cycle later. On the next ready-high arbitration, a requesting master is skipped and the grant falls to another master or to the default master. A lost release shows the same symptom and never recovers. A rotation pointer or a retry search base that is off by one changes the grant order at the first arbitration where two or more masters request together. An owner that updates on the wrong cycle shows on `owner_o` within one cycle of a stalled or BUSY beat. The bench compares grant and owner with a model built from the requirements after every clock. It runs directed split, retry, release and parking sequences, followed by a long pseudo-random sweep over all input combinations.

// File: rtl/sarb_pkg.sv
package sarb_pkg;

  typedef enum logic [1:0] {
    RSP_OKAY  = 2'b00,
    RSP_ERROR = 2'b01,
    RSP_RETRY = 2'b10,
    RSP_SPLIT = 2'b11
  } rsp_e;

  typedef enum logic [1:0] {
    XFR_IDLE   = 2'b00,
    XFR_BUSY   = 2'b01,
    XFR_NONSEQ = 2'b10,
    XFR_SEQ    = 2'b11
  } xfr_e;

endpackage

// File: rtl/sarb_rr_pick.sv
module sarb_rr_pick #(
  parameter int N  = 3,
  parameter int IW = 2
) (
  input  logic [N-1:0]  cand_i,
  input  logic [IW-1:0] base_i,
  output logic          found_o,
  output logic [IW-1:0] pick_o
);

  // Search starts one past base and wraps, so base itself is tried last.
  always_comb begin
    int c;
    found_o = 1'b0;
    pick_o  = '0;
    for (int k = 1; k <= N; k++) begin
      c = (int'(base_i) + k) % N;
      if (!found_o && cand_i[c]) begin
        found_o = 1'b1;
        pick_o  = IW'(c);
      end
    end
  end

endmodule

// File: rtl/sarb_split_mask.sv
module sarb_split_mask #(
  parameter int N  = 3,
  parameter int OW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_en_i,
  input  logic [OW-1:0] set_who_i,
  input  logic [N-1:0]  clr_i,
  output logic [N-1:0]  mask_o
);

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        mask_o[i] <= 1'b0;
      else if (clr_i[i])
        mask_o[i] <= 1'b0;                 // release beats a same-cycle block
      else if (set_en_i && set_who_i == OW'(i))
        mask_o[i] <= 1'b1;
    end

    assert_release_wins_R6: assert property (
      @(posedge clk) disable iff (!rst_n)
      clr_i[i] |=> !mask_o[i]);
  end

endmodule

// File: rtl/sarb_owner_track.sv
module sarb_owner_track #(
  parameter int N  = 3,
  parameter int OW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv_addr_i,
  input  logic          adv_data_i,
  input  logic [N-1:0]  grant_i,
  output logic [OW-1:0] owner_o,
  output logic [OW-1:0] data_owner_o
);

  localparam logic [OW-1:0] IDLE = OW'(N);

  logic [OW-1:0] grant_enc;

  always_comb begin
    grant_enc = IDLE;
    for (int i = 0; i < N; i++)
      if (grant_i[i]) grant_enc = OW'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner_o      <= IDLE;
      data_owner_o <= IDLE;
    end else begin
      if (adv_addr_i) owner_o      <= grant_enc;
      if (adv_data_i) data_owner_o <= owner_o;
    end
  end

  assert_owner_hold_R4: assert property (
    @(posedge clk) disable iff (!rst_n)
    !adv_addr_i |=> $stable(owner_o));

  assert_data_owner_hold_R4: assert property (
    @(posedge clk) disable iff (!rst_n)
    !adv_data_i |=> $stable(data_owner_o));

  assert_owner_idle_R4: assert property (
    @(posedge clk) disable iff (!rst_n)
    (adv_addr_i && grant_i == '0) |=> (owner_o == IDLE));

endmodule

// File: rtl/split_rr_arbiter.sv
module split_rr_arbiter
  import sarb_pkg::*;
#(
  parameter int N  = 3,
  parameter int IW = (N > 1) ? $clog2(N) : 1,
  parameter int OW = $clog2(N + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req_i,
  output logic [N-1:0]  grant_o,
  output logic [OW-1:0] owner_o,
  input  logic          bus_ready_i,
  input  logic [1:0]    bus_resp_i,
  input  logic [1:0]    bus_trans_i,
  input  logic [N-1:0]  release_i
);

  localparam logic [OW-1:0] IDLE = OW'(N);

  rsp_e          rsp;
  xfr_e          xfr;
  logic          adv_addr;
  logic          split_first;
  logic          retry_last;
  logic [N-1:0]  mask;
  logic [N-1:0]  eligible;
  logic [OW-1:0] data_owner;
  logic [IW-1:0] base;
  logic          found;
  logic [IW-1:0] pick;
  logic [N-1:0]  grant_q;
  logic [N-1:0]  grant_nx;
  logic [IW-1:0] ptr_q;

  assign rsp         = rsp_e'(bus_resp_i);
  assign xfr         = xfr_e'(bus_trans_i);
  assign adv_addr    = bus_ready_i && (xfr != XFR_BUSY);
  assign split_first = !bus_ready_i && (rsp == RSP_SPLIT);
  assign retry_last  = bus_ready_i && (rsp == RSP_RETRY) && (data_owner != IDLE);
  assign eligible    = req_i & ~mask;
  assign base        = retry_last ? data_owner[IW-1:0] : ptr_q;

  sarb_split_mask #(.N(N), .OW(OW)) u_mask (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_en_i  (split_first),
    .set_who_i (data_owner),
    .clr_i     (release_i),
    .mask_o    (mask)
  );

  sarb_rr_pick #(.N(N), .IW(IW)) u_pick (
    .cand_i  (eligible),
    .base_i  (base),
    .found_o (found),
    .pick_o  (pick)
  );

  always_comb begin
    if (found)        grant_nx = N'(1) << pick;
    else if (!mask[0]) grant_nx = N'(1);   // default master
    else              grant_nx = '0;       // park with nobody
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_q <= '0;
      ptr_q   <= IW'(N - 1);
    end else if (adv_addr) begin
      grant_q <= grant_nx;
      if (found)         ptr_q <= pick;
      else if (!mask[0]) ptr_q <= '0;
    end
  end

  assign grant_o = grant_q;

  sarb_owner_track #(.N(N), .OW(OW)) u_owner (
    .clk          (clk),
    .rst_n        (rst_n),
    .adv_addr_i   (adv_addr),
    .adv_data_i   (bus_ready_i),
    .grant_i      (grant_q),
    .owner_o      (owner_o),
    .data_owner_o (data_owner)
  );

  assert_one_grant_R3: assert property (
    @(posedge clk) disable iff (!rst_n)
    $onehot0(grant_q));

  assert_grant_hold_R3: assert property (
    @(posedge clk) disable iff (!rst_n)
    !adv_addr |=> $stable(grant_q));

  assert_blocked_not_granted_R5: assert property (
    @(posedge clk) disable iff (!rst_n)
    adv_addr |=> ((grant_q & $past(mask)) == '0));

  assert_retry_release_R7: assert property (
    @(posedge clk) disable iff (!rst_n)
    ((rsp == RSP_RETRY) && (release_i != '0)) |=> ((mask & $past(release_i)) == '0));

  assert_park_R9: assert property (
    @(posedge clk) disable iff (!rst_n)
    (adv_addr && eligible == '0 && mask[0]) |=> (grant_q == '0));

endmodule

// File: tb/split_rr_arbiter_tb.sv
`timescale 1ns/1ps
module split_rr_arbiter_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] req;
  logic [2:0] grant;
  logic [1:0] owner;
  logic       rdy;
  logic [1:0] resp;
  logic [1:0] trans;
  logic [2:0] rel;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // reference state built from the requirements
  int       m_grant;   // -1 none
  int       m_owner;   // 3 idle
  int       m_data;    // 3 idle
  int       m_ptr;
  bit [2:0] m_mask;

  always #2.5 clk = ~clk;

  split_rr_arbiter u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_i       (req),
    .grant_o     (grant),
    .owner_o     (owner),
    .bus_ready_i (rdy),
    .bus_resp_i  (resp),
    .bus_trans_i (trans),
    .release_i   (rel)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    int eg;
    eg = (m_grant < 0) ? 0 : (1 << m_grant);
    check(int'(grant) == eg, tag, "grant", int'(grant), eg);
    check(int'(owner) == m_owner, tag, "owner", int'(owner), m_owner);
  endtask

  task automatic model_step(input logic [2:0] r, input logic rd, input logic [1:0] rs,
                            input logic [1:0] tr, input logic [2:0] rl);
    int ng, np, no, nd, base, g, c;
    bit [2:0] nm;
    bit adv;
    ng = m_grant; np = m_ptr; no = m_owner; nd = m_data; nm = m_mask;
    adv = rd && (tr != 2'b01);
    if (adv) begin
      base = (rs == 2'b10 && m_data < 3) ? m_data : m_ptr;
      g = -1;
      for (int k = 1; k <= 3; k++) begin
        c = (base + k) % 3;
        if (g < 0 && r[c] && !m_mask[c]) g = c;
      end
      if (g < 0 && !m_mask[0]) g = 0;
      ng = g;
      if (g >= 0) np = g;
      no = (m_grant < 0) ? 3 : m_grant;
    end
    if (rd) nd = m_owner;
    if (!rd && rs == 2'b11 && m_data < 3) nm[m_data] = 1'b1;
    nm = nm & ~rl;
    m_grant = ng; m_ptr = np; m_owner = no; m_data = nd; m_mask = nm;
  endtask

  task automatic cyc(input logic [2:0] r, input logic rd, input logic [1:0] rs,
                     input logic [1:0] tr, input logic [2:0] rl, input string tag);
    req = r; rdy = rd; resp = rs; trans = tr; rel = rl;
    model_step(r, rd, rs, tr, rl);
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    bit [31:0] lf;
    rst_n = 1'b0; req = '0; rdy = 1'b1; resp = 2'b00; trans = 2'b00; rel = '0;
    m_grant = -1; m_owner = 3; m_data = 3; m_ptr = 2; m_mask = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check(grant == 3'b000, "R1", "reset grant", int'(grant), 0);
    check(owner == 2'd3, "R1", "reset owner", int'(owner), 3);
    rst_n = 1'b1;

    // R1: master 0 wins the first contest
    cyc(3'b111, 1, 2'b00, 2'b10, 3'b000, "R1");
    check(grant == 3'b001, "R1", "first grant", int'(grant), 1);

    // R2: rotation with all requesting, then a sparse pattern
    for (int i = 0; i < 6; i++) cyc(3'b111, 1, 2'b00, 2'b10, 3'b000, "R2");
    for (int i = 0; i < 4; i++) cyc(3'b101, 1, 2'b00, 2'b11, 3'b000, "R2");
    for (int i = 0; i < 3; i++) cyc(3'b110, 1, 2'b00, 2'b10, 3'b000, "R2");

    // R3: wait states freeze the grant
    for (int i = 0; i < 3; i++) cyc(3'(i + 1), 0, 2'b00, 2'b10, 3'b000, "R3");
    // R4: BUSY beats hold both grant and owner
    for (int i = 0; i < 2; i++) cyc(3'b111, 1, 2'b00, 2'b01, 3'b000, "R4");
    cyc(3'b111, 1, 2'b00, 2'b00, 3'b000, "R4");

    // R5: master 1 becomes data owner, then is split
    for (int i = 0; i < 3; i++) cyc(3'b010, 1, 2'b00, 2'b10, 3'b000, "R5");
    cyc(3'b010, 0, 2'b11, 2'b10, 3'b000, "R5");
    cyc(3'b010, 1, 2'b11, 2'b10, 3'b000, "R9");
    for (int i = 0; i < 3; i++) cyc(3'b010, 1, 2'b00, 2'b10, 3'b000, "R5");
    check(grant == 3'b001, "R5", "blocked master skipped", int'(grant), 1);

    // R7: release for master 1 lands during a RETRY
    cyc(3'b011, 0, 2'b10, 2'b10, 3'b000, "R7");
    cyc(3'b011, 1, 2'b10, 2'b10, 3'b010, "R7");
    for (int i = 0; i < 3; i++) cyc(3'b010, 1, 2'b00, 2'b10, 3'b000, "R7");
    check(grant == 3'b010, "R7", "released master granted", int'(grant), 2);

    // R6: block and release for master 2 in the same cycle
    for (int i = 0; i < 3; i++) cyc(3'b100, 1, 2'b00, 2'b10, 3'b000, "R6");
    cyc(3'b100, 0, 2'b11, 2'b10, 3'b100, "R6");
    cyc(3'b100, 1, 2'b11, 2'b10, 3'b000, "R6");
    for (int i = 0; i < 2; i++) cyc(3'b100, 1, 2'b00, 2'b10, 3'b000, "R6");
    check(grant == 3'b100, "R6", "release won", int'(grant), 4);

    // R9: block master 0, then nobody requests -> parked
    for (int i = 0; i < 3; i++) cyc(3'b001, 1, 2'b00, 2'b10, 3'b000, "R9");
    cyc(3'b000, 0, 2'b11, 2'b10, 3'b000, "R9");
    cyc(3'b000, 1, 2'b11, 2'b00, 3'b000, "R9");
    for (int i = 0; i < 3; i++) cyc(3'b000, 1, 2'b00, 2'b00, 3'b000, "R9");
    check(grant == 3'b000, "R9", "parked grant", int'(grant), 0);
    check(owner == 2'd3, "R9", "parked owner", int'(owner), 3);
    cyc(3'b000, 1, 2'b00, 2'b00, 3'b001, "R6");
    cyc(3'b000, 1, 2'b00, 2'b00, 3'b000, "R9");
    check(grant == 3'b001, "R9", "default master", int'(grant), 1);

    // R8: retried master goes to the back
    for (int i = 0; i < 3; i++) cyc(3'b011, 1, 2'b00, 2'b10, 3'b000, "R8");
    cyc(3'b111, 0, 2'b10, 2'b10, 3'b000, "R8");
    cyc(3'b111, 1, 2'b10, 2'b10, 3'b000, "R8");
    for (int i = 0; i < 4; i++) cyc(3'b111, 1, 2'b00, 2'b10, 3'b000, "R8");

    // pseudo-random sweep over all input fields
    lf = 32'h1bad_5eed;
    for (int i = 0; i < 4000; i++) begin
      lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
      cyc(lf[8:6], lf[1:0] != 2'b00, lf[3:2], lf[5:4],
          lf[11:9] & lf[14:12] & lf[17:15], "sweep R2 R5 R8");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule